// File: doc/BRIEF.md
# Request tag and response credit manager

This block sits on the application side of a memory controller whose response path has no back-pressure, and it decides which requests may be issued. Each request asks for a grant. A grant comes with a tag drawn from a free pool of `2**TAG_W` tags, and it reserves space in the application's receive buffer equal to the worst-case size of the response. A read reserves two 512-bit beats, because its payload is at most 128 bytes. A write reserves one beat, because its response has no payload. A request is granted only when a tag is free and enough credit is left. A response that then arrives at full speed always has room, even when responses come back out of order.

The block watches the beats the controller delivers into the buffer, together with a one-cycle pulse that marks each beat the application removes from the buffer. It keeps its own record of tracked beats in arrival order. A removed beat returns one beat of credit. When the removed beat is the end of a response, its tag goes back to the free pool. A read that delivers a single beat returns the unused half of its reservation as soon as its end beat is observed. A response whose tag is not in flight sets a sticky protocol-error flag and is otherwise discarded.

Top module: `tag_credit_mgr`

## Requirements
- R1: After reset `idle` is 1 and `proto_err` is 0. Tags that have never been issued are handed out first, in ascending order starting at 0.
- R2: `req_grant` is high in the same cycle as `req_valid` exactly when a free tag exists and the free credit is at least the reservation. The reservation is 2 beats when `req_is_read` is 1 and 1 beat when it is 0. `req_tag` shows the tag that the grant consumes.
- R3: The free credit starts at `CREDIT_BEATS` and drops by the reservation on every grant, starting from the next cycle.
- R4: A `cons_pulse` returns one beat of credit from the next cycle, but only while a tracked beat is waiting. A pulse with no tracked beat waiting has no effect.
- R5: On the end beat (`rsp_eop`=1) of a tracked response, the reservation minus the delivered beat count is returned to credit from the next cycle. The delivered count is 1 when `rsp_cmd0`=1. Otherwise it is `(rsp_size+4)/4`, where `rsp_size` n means (n+1)*16 bytes.
- R6: Removed beats are matched to responses in arrival order. A tag returns to the pool when its end beat is removed. Returned tags are issued again in the order they came back, after the never-issued tags. No tag is granted while it is in flight.
- R7: A beat with `rsp_valid`=1 whose `rsp_tag` is not in flight sets `proto_err`, which then stays set until reset. That beat changes neither the pool, the credit nor the tracked-beat record.
- R8: `idle` is 1 exactly when all tags are in the free pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request wants to issue this cycle |
| req_is_read | input | 1 | 1 for a read (2-beat reservation), 0 for a write (1 beat) |
| req_grant | output | 1 | Request granted this cycle |
| req_tag | output | TAG_W | Tag given with the grant |
| rsp_valid | input | 1 | A response beat is delivered into the buffer |
| rsp_tag | input | TAG_W | Tag carried by the response beat |
| rsp_eop | input | 1 | Last beat of the response |
| rsp_cmd0 | input | 1 | Command bit 0; 1 means no payload |
| rsp_size | input | 3 | Payload size code, (n+1)*16 bytes |
| cons_pulse | input | 1 | The application removed one beat from the buffer |
| idle | output | 1 | All tags free |
| proto_err | output | 1 | Sticky: a response arrived for a tag not in flight |

## Verification
Lost or extra credit shows up at `req_grant` as soon as a request needs exactly the credit that is left. It appears in the first such cycle after the fault, so the bench keeps requesting at the credit boundary. A corrupted free pool or in-flight map shows up at `req_tag` on the next grant of the affected tag, or at `idle` once traffic drains. Reuse order therefore matters and is checked on every grant. A misrouted stray response surfaces at `proto_err` one cycle later, and at the next grant that would exploit a credit or a tag it wrongly released.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
   // 16-byte payload units carried by one 512-bit beat
   localparam int unsigned UNITS_PER_BEAT = 4;

   // Beats a response occupies in the receive buffer
   function automatic logic [1:0] rsp_beats(input logic cmd0, input logic [2:0] size);
      logic [3:0] n;
      n = ({1'b0, size} + 4'(UNITS_PER_BEAT)) / 4'(UNITS_PER_BEAT);
      return cmd0 ? 2'd1 : n[1:0];
   endfunction
endpackage

// File: rtl/tcm_tag_pool.sv
module tcm_tag_pool #(
   parameter int TAG_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pop,
   input  logic             push,
   input  logic [TAG_W-1:0] push_tag,
   output logic             avail,
   output logic [TAG_W-1:0] head_tag,
   output logic             all_free
);
   localparam int NUM = 1 << TAG_W;

   logic [TAG_W-1:0] ring [NUM];
   logic [TAG_W-1:0] rd_ptr, wr_ptr;
   logic [TAG_W:0]   fresh, held;
   logic             fresh_left;

   assign fresh_left = (fresh != (TAG_W+1)'(NUM));
   assign avail      = fresh_left || (held != '0);
   assign head_tag   = fresh_left ? fresh[TAG_W-1:0] : ring[rd_ptr];
   assign all_free   = (held == fresh);

   always_ff @(posedge clk) begin
      if (push) ring[wr_ptr] <= push_tag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fresh  <= '0;
         held   <= '0;
         rd_ptr <= '0;
         wr_ptr <= '0;
      end else begin
         if (pop && fresh_left) fresh <= fresh + 1'b1;
         if (pop && !fresh_left) rd_ptr <= rd_ptr + 1'b1;
         if (push) wr_ptr <= wr_ptr + 1'b1;
         held <= held + (TAG_W+1)'(push) - (TAG_W+1)'(pop && !fresh_left);
      end
   end

   a_r2_pop_has_tag: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> avail);
   a_r6_pool_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !all_free);
endmodule

// File: rtl/tcm_credit_ctr.sv
module tcm_credit_ctr #(
   parameter int CREDIT_BEATS = 8,
   parameter int CW = $clog2(CREDIT_BEATS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] take,
   input  logic          ret_beat,
   input  logic [CW-1:0] ret_extra,
   output logic [CW-1:0] credit
);
   logic [CW+1:0] sum;

   assign sum = {2'b00, credit} + (CW+2)'(ret_beat) + {2'b00, ret_extra} - {2'b00, take};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) credit <= CW'(CREDIT_BEATS);
      else        credit <= sum[CW-1:0];
   end

   a_r3_take_covered: assert property (@(posedge clk) disable iff (!rst_n)
      take <= credit);
   a_r4_credit_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      sum <= (CW+2)'(CREDIT_BEATS));
endmodule

// File: rtl/tcm_beat_queue.sv
module tcm_beat_queue #(
   parameter int TAG_W = 9,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [TAG_W-1:0] push_tag,
   input  logic             push_eop,
   input  logic             pop_req,
   output logic             pop_fire,
   output logic [TAG_W-1:0] head_tag,
   output logic             head_eop
);
   localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [TAG_W:0]   slot [DEPTH];
   logic [PW-1:0]    rp, wp, rp_nxt, wp_nxt;
   logic [CNT_W-1:0] cnt;

   assign pop_fire = pop_req && (cnt != '0);
   assign head_tag = slot[rp][TAG_W-1:0];
   assign head_eop = slot[rp][TAG_W];

   generate
      if ((1 << PW) == DEPTH) begin : g_pow2
         assign rp_nxt = rp + 1'b1;
         assign wp_nxt = wp + 1'b1;
      end else begin : g_wrap
         assign rp_nxt = (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
         assign wp_nxt = (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) slot[wp] <= {push_eop, push_tag};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rp  <= '0;
         wp  <= '0;
         cnt <= '0;
      end else begin
         if (pop_fire) rp <= rp_nxt;
         if (push) wp <= wp_nxt;
         cnt <= cnt + CNT_W'(push) - CNT_W'(pop_fire);
      end
   end

   a_r4_queue_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop_fire) |-> (cnt < CNT_W'(DEPTH)));
endmodule

// File: rtl/tag_credit_mgr.sv
module tag_credit_mgr #(
   parameter int TAG_W        = 9,
   parameter int CREDIT_BEATS = 8,
   parameter int RD_RSV       = 2,
   parameter int WR_RSV       = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_is_read,
   output logic             req_grant,
   output logic [TAG_W-1:0] req_tag,
   input  logic             rsp_valid,
   input  logic [TAG_W-1:0] rsp_tag,
   input  logic             rsp_eop,
   input  logic             rsp_cmd0,
   input  logic [2:0]       rsp_size,
   input  logic             cons_pulse,
   output logic             idle,
   output logic             proto_err
);
   import tcm_pkg::*;

   localparam int NUM = 1 << TAG_W;
   localparam int CW  = $clog2(CREDIT_BEATS + 1);

   generate
      if (TAG_W < 1 || TAG_W > 12) begin : g_bad_tag
         $error("TAG_W out of range");
      end
      if (RD_RSV < 2 || WR_RSV < 1) begin : g_bad_rsv
         $error("reservation below worst-case response size");
      end
      if (CREDIT_BEATS < RD_RSV) begin : g_bad_credit
         $error("CREDIT_BEATS cannot hold one read response");
      end
   endgenerate

   logic             out_map [NUM];
   logic             rd_map  [NUM];
   logic [NUM-1:0]   out_vec;
   logic             pool_avail, rsp_known, track, release_tag, pop_fire, head_eop;
   logic [TAG_W-1:0] head_tag;
   logic [CW-1:0]    credit, need, take, rsv, dlv, extra;

   // issue gate
   assign need      = req_is_read ? CW'(RD_RSV) : CW'(WR_RSV);
   assign req_grant = req_valid && pool_avail && (credit >= need);
   assign take      = req_grant ? need : '0;

   // response observation
   assign rsp_known   = out_map[rsp_tag];
   assign track       = rsp_valid && rsp_known;
   assign rsv         = rd_map[rsp_tag] ? CW'(RD_RSV) : CW'(WR_RSV);
   assign dlv         = CW'(rsp_beats(rsp_cmd0, rsp_size));
   assign extra       = (track && rsp_eop && (rsv > dlv)) ? rsv - dlv : '0;
   assign release_tag = pop_fire && head_eop;

   tcm_tag_pool #(.TAG_W(TAG_W)) u_pool (
      .clk(clk), .rst_n(rst_n),
      .pop(req_grant), .push(release_tag), .push_tag(head_tag),
      .avail(pool_avail), .head_tag(req_tag), .all_free(idle)
   );

   tcm_credit_ctr #(.CREDIT_BEATS(CREDIT_BEATS), .CW(CW)) u_credit (
      .clk(clk), .rst_n(rst_n),
      .take(take), .ret_beat(pop_fire), .ret_extra(extra), .credit(credit)
   );

   tcm_beat_queue #(.TAG_W(TAG_W), .DEPTH(CREDIT_BEATS)) u_beats (
      .clk(clk), .rst_n(rst_n),
      .push(track), .push_tag(rsp_tag), .push_eop(rsp_eop),
      .pop_req(cons_pulse), .pop_fire(pop_fire),
      .head_tag(head_tag), .head_eop(head_eop)
   );

   // per-tag in-flight and read-kind map
   generate
      for (genvar i = 0; i < NUM; i++) begin : g_map
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_map[i] <= 1'b0;
               rd_map[i]  <= 1'b0;
            end else if (req_grant && (req_tag == TAG_W'(i))) begin
               out_map[i] <= 1'b1;
               rd_map[i]  <= req_is_read;
            end else if (release_tag && (head_tag == TAG_W'(i))) begin
               out_map[i] <= 1'b0;
            end
         end
         assign out_vec[i] = out_map[i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       proto_err <= 1'b0;
      else if (rsp_valid && !rsp_known) proto_err <= 1'b1;
   end

   a_r6_grant_tag_free: assert property (@(posedge clk) disable iff (!rst_n)
      req_grant |-> !out_map[req_tag]);
   a_r8_idle_matches_map: assert property (@(posedge clk) disable iff (!rst_n)
      idle == (out_vec == '0));
   a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);
   a_r6_release_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
      release_tag |-> out_map[head_tag]);
endmodule

// File: tb/tag_credit_mgr_test.sv
module tag_credit_mgr_test;
   localparam int TW   = 3;
   localparam int N    = 1 << TW;
   localparam int CRED = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 0, req_is_read = 0, rsp_valid = 0, rsp_eop = 0, rsp_cmd0 = 0, cons_pulse = 0;
   logic [TW-1:0] rsp_tag = '0;
   logic [2:0]    rsp_size = '0;
   logic          req_grant, idle, proto_err;
   logic [TW-1:0] req_tag;

   always #10 clk = ~clk;

   tag_credit_mgr #(.TAG_W(TW), .CREDIT_BEATS(CRED), .RD_RSV(2), .WR_RSV(1)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_read(req_is_read),
      .req_grant(req_grant), .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
      .rsp_eop(rsp_eop), .rsp_cmd0(rsp_cmd0), .rsp_size(rsp_size), .cons_pulse(cons_pulse),
      .idle(idle), .proto_err(proto_err)
   );

   int tests = 0, fails = 0;
   bit done = 0;

   // reference model state
   int m_credit, m_fresh, qh, qn, bh, bn;
   int m_q [N];
   bit m_out [N];
   bit m_rd [N];
   bit pend [N];
   int b_tag [CRED];
   bit b_eop [CRED];
   bit m_perr;

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_credit = CRED; m_fresh = 0; qh = 0; qn = 0; bh = 0; bn = 0; m_perr = 0;
      for (int i = 0; i < N; i++) begin m_out[i] = 0; m_rd[i] = 0; pend[i] = 0; end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; req_valid = 0; rsp_valid = 0; cons_pulse = 0;
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      model_reset();
   endtask

   task automatic step(input bit rv, input bit rrd, input bit sv, input int stag,
                       input bit seop, input bit scmd0, input int ssize, input bit cons,
                       input string lbl);
      bit eg, known, cf, ceop;
      int et, need, ctag, rsv, dl;
      @(negedge clk);
      req_valid = rv; req_is_read = rrd; rsp_valid = sv; rsp_tag = TW'(stag);
      rsp_eop = seop; rsp_cmd0 = scmd0; rsp_size = 3'(ssize); cons_pulse = cons;
      #2;
      need = rrd ? 2 : 1;
      eg = rv && (m_fresh < N || qn > 0) && (m_credit >= need);
      et = (m_fresh < N) ? m_fresh : m_q[qh];
      chk(lbl, int'(req_grant), int'(eg));
      if (eg) chk("R6 tag", int'(req_tag), et);
      chk("R8 idle", int'(idle), int'((N - m_fresh + qn) == N));
      chk("R7 proto_err", int'(proto_err), int'(m_perr));
      // next state
      known = m_out[stag];
      if (sv && !known) m_perr = 1;
      cf = cons && (bn > 0);
      ctag = b_tag[bh]; ceop = b_eop[bh];
      if (cf) m_credit++;
      if (sv && known && seop) begin
         rsv = m_rd[stag] ? 2 : 1;
         dl = scmd0 ? 1 : (ssize + 4) / 4;
         if (rsv > dl) m_credit += rsv - dl;
      end
      if (sv && known) pend[stag] = 0;
      if (eg) begin
         if (m_fresh < N) m_fresh++;
         else begin qh = (qh + 1) % N; qn--; end
         m_out[et] = 1; m_rd[et] = rrd; pend[et] = 1; m_credit -= need;
      end
      if (cf) begin
         bh = (bh + 1) % CRED; bn--;
         if (ceop) begin m_out[ctag] = 0; m_q[(qh + qn) % N] = ctag; qn++; end
      end
      if (sv && known) begin
         b_tag[(bh + bn) % CRED] = stag; b_eop[(bh + bn) % CRED] = seop; bn++;
      end
   endtask

   // responder used by sweep and drain
   bit mid = 0;
   int mid_tag = 0, mid_size = 0;
   task automatic traffic(input logic [31:0] r, input bit rv, input bit force_rsp, input bit cons);
      bit sv = 0, eop = 0, c0 = 0, found = 0;
      int tg = 0, sz = 0;
      if (mid) begin
         sv = 1; tg = mid_tag; eop = 1; sz = mid_size; mid = 0;
      end else if (r[5] || force_rsp) begin
         for (int k = 0; k < N; k++) begin
            int t;
            t = (int'(r[10:8]) + k) % N;
            if (!found && pend[t]) begin found = 1; tg = t; end
         end
         if (found) begin
            sv = 1;
            if (m_rd[tg]) begin
               sz = int'(r[13:11]);
               if (sz >= 4) begin eop = 0; mid = 1; mid_tag = tg; mid_size = sz; end
               else eop = 1;
            end else begin
               c0 = 1; eop = 1; sz = int'(r[13:11]);
            end
         end
      end
      step(rv, r[2], sv, tg, eop, c0, sz, cons, "R2 grant");
   endtask

   initial begin
      logic [31:0] lf;
      model_reset();
      do_reset();
      // R1: reset state, first tag 0
      chk("R1 idle after reset", int'(idle), 1);
      chk("R1 proto_err after reset", int'(proto_err), 0);
      step(1, 1, 0, 0, 0, 0, 0, 0, "R1 first read");
      // R3: credit consumption
      step(1, 1, 0, 0, 0, 0, 0, 0, "R3 second read");
      step(1, 1, 0, 0, 0, 0, 0, 0, "R3 read over credit");
      step(1, 0, 0, 0, 0, 0, 0, 0, "R3 write on last beat");
      step(1, 0, 0, 0, 0, 0, 0, 0, "R3 write at zero credit");
      // R4: consume with nothing tracked is ignored
      step(1, 0, 0, 0, 0, 0, 0, 1, "R4 empty consume");
      step(1, 0, 0, 0, 0, 0, 0, 0, "R4 after empty consume");
      step(1, 0, 1, 1, 0, 0, 7, 0, "R4 beat one of tag1");
      step(1, 0, 1, 1, 1, 0, 7, 0, "R4 beat two of tag1");
      step(1, 0, 0, 0, 0, 0, 0, 1, "R4 consume cycle");
      step(1, 0, 0, 0, 0, 0, 0, 0, "R4 credit returned");
      // R5: short read returns unused half
      step(1, 0, 1, 0, 1, 0, 1, 0, "R5 short read response");
      step(1, 0, 0, 0, 0, 0, 0, 0, "R5 unused credit returned");
      // R6: tag recycling order
      step(0, 0, 0, 0, 0, 0, 0, 1, "R6 consume tag1 end");
      step(0, 0, 0, 0, 0, 0, 0, 1, "R6 consume tag0 end");
      step(1, 0, 0, 0, 0, 0, 0, 0, "R6 fresh tag5");
      step(1, 0, 0, 0, 0, 0, 0, 0, "R6 fresh tag6");
      step(0, 0, 1, 2, 1, 1, 0, 0, "R6 write response tag2");
      step(0, 0, 1, 3, 1, 1, 0, 1, "R6 write response tag3");
      step(0, 0, 0, 0, 0, 0, 0, 1, "R6 consume tag3");
      step(1, 0, 0, 0, 0, 0, 0, 0, "R6 fresh tag7");
      step(1, 0, 0, 0, 0, 0, 0, 0, "R6 recycled tag1");
      // R7: stray response on free tag0 (was a read) must do nothing
      step(0, 0, 1, 0, 1, 1, 0, 0, "R7 stray response");
      step(1, 0, 0, 0, 0, 0, 0, 0, "R7 no credit from stray");
      step(1, 0, 0, 0, 0, 0, 0, 1, "R7 stray not tracked");
      step(1, 0, 0, 0, 0, 0, 0, 0, "R7 still no credit");
      // sweep
      do_reset();
      chk("R1 idle after second reset", int'(idle), 1);
      chk("R1 proto_err cleared", int'(proto_err), 0);
      mid = 0;
      lf = 32'h1234_5679;
      for (int c = 0; c < 4000; c++) begin
         lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
         traffic(lf, lf[0] | lf[1], 1'b0, lf[3] | lf[4]);
      end
      // drain
      for (int c = 0; c < 200; c++) begin
         lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
         traffic(lf, 1'b0, 1'b1, 1'b1);
      end
      @(negedge clk); #2;
      chk("R8 idle after drain", int'(idle), 1);
      chk("R7 no error in legal traffic", int'(proto_err), 0);
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      #4000000;
      if (!done) begin
         done = 1;
         tests++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule